// File: doc/BRIEF.md
# Compare and Test Flag Unit

This unit evaluates one condition per request and records the outcome in a single-bit status flag, T. The condition can be a comparison between two 32-bit operands, a comparison of one operand against an immediate, or a sign test on one operand. It can also be a lane-wise equality search, a bitwise AND-is-zero test, or a decrement followed by a zero test. The flag is set to 1 when the condition holds and cleared to 0 when it does not. No other status bit is touched.

A request is a single cycle with `in_valid` high, carrying the operation code, the operands and the immediate. The unit takes a new request on every clock cycle and never applies back-pressure, so the upstream side needs no ready signal. On the edge that samples the request, T is written and the `done` pulse is registered, so both are visible in the cycle that follows. The decrement operation also returns its decremented operand on `dec_value`. That register changes only for that operation.

Top module: `cmp_tflag_unit`

## Requirements
- R1: While `rst_n` is low, `t_flag`, `done` and `dec_value` are all 0.
- R2: Each cycle with `in_valid` high gives `done` = 1 in the following cycle and writes T on that same edge. A cycle with `in_valid` low gives `done` = 0 in the following cycle and leaves T unchanged.
- R3: Code 4'h0 sets T when A equals B. Code 4'h1 sets T when A equals the immediate, with both taken as 32-bit two's-complement values.
- R4: Unsigned compares: code 4'h2 sets T when B >= A, and code 4'h3 sets T when B > A.
- R5: Signed two's-complement compares: code 4'h4 sets T when B >= A, and code 4'h5 sets T when B > A.
- R6: Code 4'h6 sets T when A, read as signed, is strictly greater than zero. Code 4'h7 sets T when A is greater than or equal to zero.
- R7: Code 4'h8 sets T when at least one of the byte lanes [7:0], [15:8], [23:16], [31:24] of A equals the same lane of B.
- R8: Code 4'h9 sets T when (A & B) == 0. Code 4'hA sets T when (A & immediate) == 0.
- R9: Code 4'hB loads `dec_value` with A − 1 (modulo 2^32) and sets T when that result is zero. Every other code leaves `dec_value` unchanged.
- R10: Codes 4'hC to 4'hF leave T unchanged but still produce the `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one request per high cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| imm | input | 32 | Immediate operand |
| t_flag | output | 1 | Status flag T |
| done | output | 1 | One-cycle pulse after each request |
| dec_value | output | 32 | Result of the last decrement operation |

## Verification
The assertions check on every cycle that a request and its `done` pulse stay paired one-for-one. They also check that T holds across idle cycles and unused codes, that `dec_value` moves only on a decrement, and the sign-bit bound of the non-negative test. The correct truth value of each comparison at its boundaries needs the directed scenarios. These include equal operands, the most negative value, zero, all-ones and a match confined to a single byte lane. The scenarios also cover the wrap of the decrement from zero and the difference between signed and unsigned order for the same bit patterns.

// File: rtl/cmp_tflag_pkg.sv
package cmp_tflag_pkg;
  typedef enum logic [3:0] {
    OP_EQ    = 4'h0,
    OP_EQI   = 4'h1,
    OP_UGE   = 4'h2,
    OP_UGT   = 4'h3,
    OP_SGE   = 4'h4,
    OP_SGT   = 4'h5,
    OP_POS   = 4'h6,
    OP_NNEG  = 4'h7,
    OP_LANEQ = 4'h8,
    OP_ANDZ  = 4'h9,
    OP_ANDZI = 4'hA,
    OP_DECZ  = 4'hB
  } cmp_op_e;

  typedef struct packed {
    logic hit;
    logic write;
  } flag_upd_t;
endpackage

// File: rtl/cmp_magnitude.sv
module cmp_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         u_ge,
  output logic         u_gt,
  output logic         s_ge,
  output logic         s_gt
);
  // Each compare answers "rhs versus lhs".
  // The signed order is the unsigned order after flipping both sign bits.
  localparam int EW = W + 1;

  logic [EW-1:0] u_diff;
  logic [EW-1:0] s_diff;
  logic [W-1:0]  lhs_s;
  logic [W-1:0]  rhs_s;
  logic          same;

  always_comb begin
    lhs_s = lhs ^ {1'b1, {(W-1){1'b0}}};
    rhs_s = rhs ^ {1'b1, {(W-1){1'b0}}};
    u_diff = {1'b0, rhs} - {1'b0, lhs};
    s_diff = {1'b0, rhs_s} - {1'b0, lhs_s};
    same = (rhs == lhs);
    u_ge = ~u_diff[W];
    s_ge = ~s_diff[W];
    u_gt = u_ge & ~same;
    s_gt = s_ge & ~same;
  end
endmodule

// File: rtl/cmp_lane_match.sv
module cmp_lane_match #(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         any_hit
);
  localparam int NLANES = W / LANE_W;

  logic [NLANES-1:0] hit;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign hit[g] = (x[g*LANE_W +: LANE_W] == y[g*LANE_W +: LANE_W]);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/cmp_flag_eval.sv
module cmp_flag_eval
  import cmp_tflag_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  output flag_upd_t    upd,
  output logic [W-1:0] dec_res
);
  logic u_ge, u_gt, s_ge, s_gt, lane_any;

  cmp_magnitude #(.W(W)) u_mag (
    .lhs(a), .rhs(b), .u_ge(u_ge), .u_gt(u_gt), .s_ge(s_ge), .s_gt(s_gt)
  );

  cmp_lane_match #(.W(W), .LANE_W(LANE_W)) u_lane (
    .x(a), .y(b), .any_hit(lane_any)
  );

  always_comb begin
    dec_res   = a - W'(1);
    upd.write = 1'b1;
    upd.hit   = 1'b0;
    case (op)
      OP_EQ:    upd.hit = (a == b);
      OP_EQI:   upd.hit = ($signed(a) == $signed(k));
      OP_UGE:   upd.hit = u_ge;
      OP_UGT:   upd.hit = u_gt;
      OP_SGE:   upd.hit = s_ge;
      OP_SGT:   upd.hit = s_gt;
      OP_POS:   upd.hit = ~a[W-1] & (|a);
      OP_NNEG:  upd.hit = ~a[W-1];
      OP_LANEQ: upd.hit = lane_any;
      OP_ANDZ:  upd.hit = ((a & b) == '0);
      OP_ANDZI: upd.hit = ((a & k) == '0);
      OP_DECZ:  upd.hit = (dec_res == '0);
      default:  upd.write = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_tflag_unit.sv
module cmp_tflag_unit
  import cmp_tflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] imm,
  output logic              t_flag,
  output logic              done,
  output logic [DATA_W-1:0] dec_value
);
  flag_upd_t         upd;
  logic [DATA_W-1:0] dec_res;

  cmp_flag_eval #(.W(DATA_W), .LANE_W(LANE_W)) u_eval (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .k(imm), .upd(upd), .dec_res(dec_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_flag    <= 1'b0;
      done      <= 1'b0;
      dec_value <= '0;
    end else begin
      done <= in_valid;
      if (in_valid && upd.write) t_flag <= upd.hit;
      if (in_valid && op_sel == OP_DECZ) dec_value <= dec_res;
    end
  end

  assert_done_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  assert_done_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(t_flag));
  assert_unused_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel >= 4'hC) |=> $stable(t_flag));
  assert_eq_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_EQ && opnd_a == opnd_b) |=> t_flag);
  assert_nneg_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_NNEG && opnd_a[DATA_W-1]) |=> !t_flag);
  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op_sel == OP_DECZ) |=> $stable(dec_value));
endmodule

// File: tb/sim_cmp_tflag_unit.sv
module sim_cmp_tflag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, imm = '0;
  logic        t_flag, done;
  logic [31:0] dec_value;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_tflag_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .t_flag(t_flag), .done(done), .dec_value(dec_value)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drives one request at a falling edge; results are sampled one falling edge later.
  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] k, input logic exp_t);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; imm = k;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "t_flag", {31'b0, t_flag}, {31'b0, exp_t});
    chk("R2", "done", {31'b0, done}, 32'd1);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "t_flag", {31'b0, t_flag}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "dec_value", dec_value, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_R2();
    run_op("R2", 4'h0, 32'd9, 32'd9, 32'd0, 1'b1);
    @(negedge clk);
    chk("R2", "idle done", {31'b0, done}, 32'd0);
    chk("R2", "idle t_flag", {31'b0, t_flag}, 32'd1);
  endtask

  task automatic t_equal_R3();
    run_op("R3", 4'h0, 32'd5, 32'd5, 32'd0, 1'b1);
    run_op("R3", 4'h0, 32'd5, 32'd6, 32'd0, 1'b0);
    run_op("R3", 4'h1, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 1'b1);
    run_op("R3", 4'h1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd7, 1'b0);
  endtask

  task automatic t_unsigned_R4();
    run_op("R4", 4'h2, 32'd10, 32'd10, 32'd0, 1'b1);
    run_op("R4", 4'h3, 32'd10, 32'd10, 32'd0, 1'b0);
    run_op("R4", 4'h3, 32'd1, 32'hFFFFFFFF, 32'd0, 1'b1);
    run_op("R4", 4'h2, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0);
  endtask

  task automatic t_signed_R5();
    run_op("R5", 4'h4, 32'd1, 32'hFFFFFFFF, 32'd0, 1'b0);
    run_op("R5", 4'h5, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'd0, 1'b1);
    run_op("R5", 4'h4, 32'h80000000, 32'h80000000, 32'd0, 1'b1);
    run_op("R5", 4'h5, 32'h80000000, 32'h80000000, 32'd0, 1'b0);
    run_op("R5", 4'h5, 32'h80000000, 32'h7FFFFFFF, 32'd0, 1'b1);
  endtask

  task automatic t_sign_R6();
    run_op("R6", 4'h6, 32'd0, 32'd0, 32'd0, 1'b0);
    run_op("R6", 4'h6, 32'd1, 32'd0, 32'd0, 1'b1);
    run_op("R6", 4'h6, 32'h80000000, 32'd0, 32'd0, 1'b0);
    run_op("R6", 4'h7, 32'd0, 32'd0, 32'd0, 1'b1);
    run_op("R6", 4'h7, 32'hFFFFFFFF, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_lanes_R7();
    run_op("R7", 4'h8, 32'h12345678, 32'hAB34CDEF, 32'd0, 1'b1);
    run_op("R7", 4'h8, 32'h11223344, 32'h55667788, 32'd0, 1'b0);
    run_op("R7", 4'h8, 32'hAA000000, 32'hAA111111, 32'd0, 1'b1);
    run_op("R7", 4'h8, 32'h01020304, 32'h10203004, 32'd0, 1'b1);
  endtask

  task automatic t_andz_R8();
    run_op("R8", 4'h9, 32'h000000F0, 32'h0000000F, 32'd0, 1'b1);
    run_op("R8", 4'h9, 32'h000000F0, 32'h00000010, 32'd0, 1'b0);
    run_op("R8", 4'hA, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1);
    run_op("R8", 4'hA, 32'h80000000, 32'd0, 32'h80000000, 1'b0);
  endtask

  task automatic t_decz_R9();
    run_op("R9", 4'hB, 32'd1, 32'd0, 32'd0, 1'b1);
    chk("R9", "dec_value", dec_value, 32'd0);
    run_op("R9", 4'hB, 32'd0, 32'd0, 32'd0, 1'b0);
    chk("R9", "dec_value wrap", dec_value, 32'hFFFFFFFF);
    run_op("R9", 4'hB, 32'd5, 32'd0, 32'd0, 1'b0);
    chk("R9", "dec_value", dec_value, 32'd4);
    run_op("R9", 4'h0, 32'd3, 32'd3, 32'd0, 1'b1);
    chk("R9", "dec_value kept", dec_value, 32'd4);
  endtask

  task automatic t_unused_R10();
    run_op("R10", 4'h0, 32'd1, 32'd1, 32'd0, 1'b1);
    run_op("R10", 4'hC, 32'd0, 32'd5, 32'd0, 1'b1);
    run_op("R10", 4'h0, 32'd1, 32'd2, 32'd0, 1'b0);
    run_op("R10", 4'hF, 32'd0, 32'd0, 32'd0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_idle_R2();
    t_equal_R3();
    t_unsigned_R4();
    t_signed_R5();
    t_sign_R6();
    t_lanes_R7();
    t_andz_R8();
    t_decz_R9();
    t_unused_R10();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule